// File: doc/BRIEF.md
# Single-Cycle Asynchronous SRAM Access Controller

This controller sits between a host port and an asynchronous static RAM and turns every accepted request into a bus cycle that is exactly one system clock long. Address and write data are launched on a rising clock edge and stay put until the next rising edge. The active-low write and output strobes are low only during the high phase of that cycle. They then return high at the falling edge, so about half a cycle of address and data hold remains before the bus moves on.

Each strobe is shaped without glitches. A level-sensitive enable is open while the clock is low, so it follows the request decision for the coming cycle. It closes while the clock is high, and its output is NAND-combined with the clock. The controller inserts a single bus turnaround cycle only when a write directly follows a read. During that cycle, ready is low and the deferred write waits in a holding register. A write followed by a read runs back to back with no gap.

Top module: `sram1c_ctrl`

## Requirements
- R1: After reset, `mem_we_n` and `mem_oe_n` are 1, `mem_dq_oe` is 0, `host_ready` is 1 and `rd_valid` is 0.
- R2: A write accepted on rising edge k drives its address on `mem_addr` and its data on `mem_dq_out`, with `mem_dq_oe` = 1, for the whole cycle from edge k to edge k+1.
- R3: During a write cycle, `mem_we_n` is 0 while the clock is high and 1 while the clock is low. It is 1 in every cycle that is not a write.
- R4: During a read cycle, `mem_oe_n` is 0 while the clock is high and 1 while the clock is low. It is 1 in every cycle that is not a read, and `mem_dq_oe` is 0 during reads.
- R5: A read accepted on edge k samples `mem_dq_in` on edge k+1. After edge k+1, `rd_valid` is 1 for one cycle and `rd_data` holds the sampled word.
- R6: A write accepted on the edge right after a read was accepted is deferred. The following cycle is idle: no strobe, `mem_dq_oe` = 0, `host_ready` = 0. The write then runs in the next cycle with the address and data captured at acceptance, and host inputs during the idle cycle have no effect.
- R7: A read accepted right after a write starts on the next edge with no idle cycle, and `host_ready` stays 1.
- R8: A cycle with no accepted request drives no strobe and leaves `mem_dq_oe` at 0.
- R9: Consecutive reads, or consecutive writes, run one per clock with `host_ready` held at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; bus cycles run from rising edge to rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_valid | input | 1 | Request present |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Request address |
| host_wdata | input | DATA_W | Write data |
| host_ready | output | 1 | Request accepted on the next rising edge when high |
| rd_data | output | DATA_W | Word returned by the last read |
| rd_valid | output | 1 | `rd_data` is new this cycle |
| mem_addr | output | ADDR_W | SRAM address |
| mem_dq_out | output | DATA_W | Data driven toward the SRAM |
| mem_dq_oe | output | 1 | Tri-state enable for `mem_dq_out` |
| mem_dq_in | input | DATA_W | Data returned by the SRAM |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output enable |

## Verification
The bench builds the controller with a 4-bit address and 8-bit data. The bench's behavioural SRAM therefore covers the whole address space, and stale or misrouted words show up on read-back. The strobes are sampled in both clock phases of each cycle, which exposes a strobe that spans the full cycle or sits in the wrong phase. The read-to-write case changes the host inputs during the idle cycle, which shows whether the held write, rather than the live inputs, reaches the memory.

// File: rtl/sram1c_pkg.sv
package sram1c_pkg;
   typedef enum logic [1:0] {
      SLOT_IDLE = 2'd0,
      SLOT_RD   = 2'd1,
      SLOT_WR   = 2'd2
   } slot_e;
endpackage

// File: rtl/sram1c_seq.sv
module sram1c_seq
   import sram1c_pkg::*;
#(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              ready,
   output slot_e             nxt_kind,
   output slot_e             cur_kind,
   output logic [ADDR_W-1:0] cur_addr,
   output logic [DATA_W-1:0] cur_wdata
);
   logic              hold_q;
   logic [ADDR_W-1:0] hold_addr;
   logic [DATA_W-1:0] hold_wdata;
   logic              defer;
   logic [ADDR_W-1:0] nxt_addr;
   logic [DATA_W-1:0] nxt_wdata;

   // a write landing right after a read must wait one turnaround cycle
   assign defer = !hold_q && req_valid && req_write && (cur_kind == SLOT_RD);
   assign ready = !hold_q;

   always_comb begin
      nxt_kind  = SLOT_IDLE;
      nxt_addr  = cur_addr;
      nxt_wdata = cur_wdata;
      if (hold_q) begin
         nxt_kind  = SLOT_WR;
         nxt_addr  = hold_addr;
         nxt_wdata = hold_wdata;
      end else if (req_valid && !defer) begin
         nxt_kind  = req_write ? SLOT_WR : SLOT_RD;
         nxt_addr  = req_addr;
         nxt_wdata = req_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_kind   <= SLOT_IDLE;
         cur_addr   <= '0;
         cur_wdata  <= '0;
         hold_q     <= 1'b0;
         hold_addr  <= '0;
         hold_wdata <= '0;
      end else begin
         cur_kind  <= nxt_kind;
         cur_addr  <= nxt_addr;
         cur_wdata <= nxt_wdata;
         hold_q    <= defer;
         if (defer) begin
            hold_addr  <= req_addr;
            hold_wdata <= req_wdata;
         end
      end
   end
endmodule

// File: rtl/sram1c_strobe.sv
module sram1c_strobe (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   output logic strobe_n
);
   logic en_q;

   // open while clk is low, frozen while clk is high: no glitch at the gate
   always_latch begin
      if (!clk) en_q = arm & rst_n;
   end

   assign strobe_n = ~(en_q & clk);
endmodule

// File: rtl/sram1c_rcap.sv
module sram1c_rcap #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout,
   output logic              dout_valid
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout       <= '0;
         dout_valid <= 1'b0;
      end else begin
         dout_valid <= capture;
         if (capture) dout <= din;
      end
   end
endmodule

// File: rtl/sram1c_ctrl.sv
module sram1c_ctrl
   import sram1c_pkg::*;
#(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_valid,
   input  logic              host_write,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   output logic              host_ready,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_dq_out,
   output logic              mem_dq_oe,
   input  logic [DATA_W-1:0] mem_dq_in,
   output logic              mem_we_n,
   output logic              mem_oe_n
);
   localparam int NSTROBE = 2;

   generate
      if (ADDR_W < 1 || ADDR_W > 32) begin : g_bad_addr
         $error("sram1c_ctrl: ADDR_W out of range");
      end
      if (DATA_W < 1 || DATA_W > 128) begin : g_bad_data
         $error("sram1c_ctrl: DATA_W out of range");
      end
   endgenerate

   slot_e              nxt_kind, cur_kind;
   logic [NSTROBE-1:0] arm, strobe_n;

   sram1c_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (host_valid),
      .req_write (host_write),
      .req_addr  (host_addr),
      .req_wdata (host_wdata),
      .ready     (host_ready),
      .nxt_kind  (nxt_kind),
      .cur_kind  (cur_kind),
      .cur_addr  (mem_addr),
      .cur_wdata (mem_dq_out)
   );

   // index 0 shapes the write strobe, index 1 the output enable
   assign arm[0] = (nxt_kind == SLOT_WR);
   assign arm[1] = (nxt_kind == SLOT_RD);

   generate
      for (genvar s = 0; s < NSTROBE; s++) begin : g_strobe
         sram1c_strobe u_strobe (
            .clk      (clk),
            .rst_n    (rst_n),
            .arm      (arm[s]),
            .strobe_n (strobe_n[s])
         );
      end
   endgenerate

   assign mem_we_n  = strobe_n[0];
   assign mem_oe_n  = strobe_n[1];
   assign mem_dq_oe = (cur_kind == SLOT_WR);

   sram1c_rcap #(.DATA_W(DATA_W)) u_rcap (
      .clk        (clk),
      .rst_n      (rst_n),
      .capture    (cur_kind == SLOT_RD),
      .din        (mem_dq_in),
      .dout       (rd_data),
      .dout_valid (rd_valid)
   );
endmodule

// File: rtl/sram1c_ctrl_chk.sv
module sram1c_ctrl_chk #(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              host_valid,
   input logic              host_write,
   input logic              host_ready,
   input logic              rd_valid,
   input logic              mem_dq_oe,
   input logic              mem_we_n,
   input logic              mem_oe_n,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [DATA_W-1:0] rd_data
);
   logic acc_rd, acc_wr;
   assign acc_rd = host_valid && host_ready && !host_write;
   assign acc_wr = host_valid && host_ready && host_write;

   // R3
   we_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we_n);
   // R4
   oe_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_oe_n);
   // R6
   turnaround_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !host_ready |=> host_ready);
   // R6
   turnaround_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !host_ready |-> !mem_dq_oe);
   // R6
   rd_wr_defer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_wr && $past(acc_rd)) |=> !host_ready);
   // R7
   wr_rd_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_rd && $past(acc_wr)) |=> host_ready);
   // R5
   rd_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc_rd |=> ##1 rd_valid);
   // R2
   wr_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_wr && !$past(acc_rd)) |=> mem_dq_oe);

   wire unused_ok = ^{mem_addr, rd_data};
endmodule

bind sram1c_ctrl sram1c_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .host_valid (host_valid),
   .host_write (host_write),
   .host_ready (host_ready),
   .rd_valid   (rd_valid),
   .mem_dq_oe  (mem_dq_oe),
   .mem_we_n   (mem_we_n),
   .mem_oe_n   (mem_oe_n),
   .mem_addr   (mem_addr),
   .rd_data    (rd_data)
);

// File: tb/test_sram1c_ctrl.sv
`timescale 1ns/1ps
module test_sram1c_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 4;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          host_valid = 1'b0, host_write = 1'b0;
   logic [AW-1:0] host_addr = '0;
   logic [DW-1:0] host_wdata = '0;
   logic          host_ready, rd_valid, mem_dq_oe, mem_we_n, mem_oe_n;
   logic [DW-1:0] rd_data, mem_dq_out, mem_dq_in;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem [0:(1<<AW)-1];
   int            n_chk = 0, n_bad = 0;
   logic          done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sram1c_ctrl #(.ADDR_W(AW), .DATA_W(DW)) i_sram1c_ctrl (
      .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_write(host_write),
      .host_addr(host_addr), .host_wdata(host_wdata), .host_ready(host_ready),
      .rd_data(rd_data), .rd_valid(rd_valid), .mem_addr(mem_addr),
      .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in),
      .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n)
   );

   // behavioural SRAM: stores on the rising edge of the write strobe
   always @(posedge mem_we_n) if (rst_n && mem_dq_oe) mem[mem_addr] = mem_dq_out;
   assign mem_dq_in = mem[mem_addr];

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   // put a request up in the low phase, then step to just after the edge
   task automatic issue(input logic v, input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      host_valid = v; host_write = w; host_addr = a; host_wdata = d;
      @(posedge clk); #2;
   endtask

   task automatic expect_write(input string req, input logic [AW-1:0] a, input logic [DW-1:0] d);
      chk({req, " we_n high phase"}, mem_we_n, 0);
      chk({req, " oe_n"}, mem_oe_n, 1);
      chk({req, " dq_oe"}, mem_dq_oe, 1);
      chk({req, " addr"}, mem_addr, a);
      chk({req, " data"}, mem_dq_out, d);
   endtask

   task automatic low_phase_check(input string req, input logic oe_exp);
      @(negedge clk); #2;
      chk({req, " we_n low phase"}, mem_we_n, 1);
      chk({req, " oe_n low phase"}, mem_oe_n, 1);
      chk({req, " dq_oe held"}, mem_dq_oe, oe_exp);
   endtask

   task automatic t_reset();
      for (int i = 0; i < (1<<AW); i++) mem[i] = 8'h00;
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      #2;
      chk("R1 we_n", mem_we_n, 1);
      chk("R1 oe_n", mem_oe_n, 1);
      chk("R1 dq_oe", mem_dq_oe, 0);
      chk("R1 ready", host_ready, 1);
      chk("R1 rd_valid", rd_valid, 0);
      @(negedge clk); rst_n = 1'b1;
   endtask

   task automatic t_single_write();
      issue(1, 1, 4'h3, 8'hA5);
      expect_write("R2 R3", 4'h3, 8'hA5);
      host_valid = 0;
      #1; low_phase_check("R3", 1);
      @(posedge clk); #2;
      chk("R3 no strobe after", mem_we_n, 1);
      chk("R8 bus released", mem_dq_oe, 0);
      chk("R2 stored", mem[3], 8'hA5);
   endtask

   task automatic t_single_read();
      mem[9] = 8'h3C;
      issue(1, 0, 4'h9, 8'h00);
      chk("R4 oe_n high phase", mem_oe_n, 0);
      chk("R4 we_n", mem_we_n, 1);
      chk("R4 dq_oe off", mem_dq_oe, 0);
      chk("R4 addr", mem_addr, 4'h9);
      host_valid = 0;
      chk("R5 not yet valid", rd_valid, 0);
      low_phase_check("R4", 0);
      @(posedge clk); #2;
      chk("R5 rd_valid", rd_valid, 1);
      chk("R5 rd_data", rd_data, 8'h3C);
      chk("R8 idle oe_n", mem_oe_n, 1);
      @(posedge clk); #2;
      chk("R5 one pulse", rd_valid, 0);
   endtask

   task automatic t_read_then_write();
      mem[5] = 8'h77; mem[6] = 8'h11; mem[7] = 8'h22;
      issue(1, 0, 4'h5, 8'h00);
      chk("R6 read runs", mem_oe_n, 0);
      issue(1, 1, 4'h6, 8'hC3);
      chk("R6 ready low", host_ready, 0);
      chk("R6 idle dq_oe", mem_dq_oe, 0);
      chk("R6 idle we_n", mem_we_n, 1);
      chk("R6 idle oe_n", mem_oe_n, 1);
      chk("R5 rd_data", rd_data, 8'h77);
      issue(1, 1, 4'h7, 8'hEE);
      expect_write("R6 held", 4'h6, 8'hC3);
      chk("R6 ready back", host_ready, 1);
      host_valid = 0;
      @(posedge clk); #2;
      chk("R6 held stored", mem[6], 8'hC3);
      chk("R6 ignored input", mem[7], 8'h22);
   endtask

   task automatic t_write_then_read();
      mem[2] = 8'h5A;
      issue(1, 1, 4'h1, 8'h99);
      expect_write("R7 write", 4'h1, 8'h99);
      issue(1, 0, 4'h2, 8'h00);
      chk("R7 ready", host_ready, 1);
      chk("R7 read at once", mem_oe_n, 0);
      chk("R7 addr", mem_addr, 4'h2);
      host_valid = 0;
      @(posedge clk); #2;
      chk("R7 rd_data", rd_data, 8'h5A);
      chk("R7 written", mem[1], 8'h99);
   endtask

   task automatic t_streams();
      for (int i = 8; i < 12; i++) begin
         issue(1, 1, AW'(i), DW'(8'h40 + i));
         expect_write("R9 write stream", AW'(i), DW'(8'h40 + i));
         chk("R9 ready", host_ready, 1);
      end
      for (int i = 8; i < 12; i++) begin
         issue(1, 0, AW'(i), 8'h00);
         chk("R9 read stream oe", mem_oe_n, 0);
         chk("R9 ready", host_ready, 1);
         if (i > 8) chk("R9 read data", rd_data, DW'(8'h40 + i - 1));
      end
      host_valid = 0;
      @(posedge clk); #2;
      chk("R9 last read", rd_data, 8'h4B);
      issue(0, 1, 4'h0, 8'hFF);
      chk("R8 no we", mem_we_n, 1);
      chk("R8 no oe", mem_oe_n, 1);
      chk("R8 undriven", mem_dq_oe, 0);
   endtask

   initial begin
      t_reset();
      t_single_write();
      t_single_read();
      t_read_then_write();
      t_write_then_read();
      t_streams();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (5000) @(posedge clk);
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule